// File: doc/BRIEF.md
# Double-Buffered Calibration Trigger Controller

This block launches a fixed-length calibration run from a control register that exists twice: a shadow copy that takes writes and an active copy that the logic acts on. Writes change only the shadow copy. A separate update strobe moves the shadow copy into the active copy in one step. A run is triggered by the active go bit changing from 0 to 1 during an update, and only while the reference-present input is high. A level that stays high does not start a run.

The block divides its reference clock by 2, 4, 8 or 16, selected by a field in the active register, to produce the calibration clock. The divider restarts at each launch, so the first calibration clock period is always complete. The busy flag stays high for a fixed number of calibration clock periods. A single-cycle done pulse then follows in the reference clock domain. Software starts a run in four steps: write go=0, update, write go=1, update.

Top module: `calt_top`

## Requirements
- R1: After reset, busy, done and cal_clk are low, the active and shadow go bits are 0 and both divider selects are 2'b11.
- R2: A write alone changes only the shadow copy. Without an update strobe, no run starts and the divide ratio does not change.
- R3: A run starts on the clock edge where upd is high, the shadow go bit is 1, the active go bit is 0 and ref_present is high. busy is high from the next cycle.
- R4: An update that leaves the active go bit at 1, with no 0-to-1 change, starts no run.
- R5: A 0-to-1 change of the active go bit while ref_present is low starts no run. That change is consumed: the go bit must return to 0 before a later run can start.
- R6: The divider select field gives the ratio N: 2'b00=2, 2'b01=4, 2'b10=8, 2'b11=16. busy stays high for exactly 64*N reference cycles.
- R7: done is high for exactly one cycle, in the first cycle where busy is low after a run. It is low at all other times.
- R8: A 0-to-1 change of the active go bit while busy is high is ignored. The current run keeps its length and no second run follows.
- R9: The divider restarts at launch. cal_clk is low in the first busy cycle and goes high N/2 cycles later.
- R10: The go bit and the divider select have separate write enables. A write to one field leaves the other field of the shadow copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_go_en | input | 1 | Write enable for the shadow go bit |
| wr_go | input | 1 | Go bit value to write |
| wr_sel_en | input | 1 | Write enable for the shadow divider select |
| wr_sel | input | 2 | Divider select value to write |
| upd | input | 1 | Update strobe, copies shadow into active |
| ref_present | input | 1 | Reference signal present indication |
| cal_clk | output | 1 | Divided calibration clock |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The trigger is tried with five patterns:
- A write with no update, which separates the shadow copy from the active copy.
- An update while ref_present is low, which checks the reference gate.
- A repeated update with the go bit still at 1, which separates edge detection from level detection.
- The full four-step sequence with every divider select and with the reset default, which checks the ratio encoding through the busy length.
- A second four-step sequence issued while busy, which checks that an edge during a run cannot restart it.

For each run, the cal_clk phase at the start of the run shows whether the divider restarted.

// File: rtl/calt_pkg.sv
package calt_pkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic             go;
    logic [SEL_W-1:0] sel;
  } calt_ctrl_t;

  localparam calt_ctrl_t CTRL_RST = '{go: 1'b0, sel: {SEL_W{1'b1}}};

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } calt_state_e;
endpackage

// File: rtl/calt_rst_sync.sv
module calt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/calt_regs.sv
module calt_regs
  import calt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go_en,
  input  logic             wr_go,
  input  logic             wr_sel_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             upd,
  output calt_ctrl_t       act_o,
  output logic             go_rise_o
);
  calt_ctrl_t shd_q, shd_d;
  calt_ctrl_t act_q, act_d;

  // Shadow copy: each field has its own enable
  always_comb begin
    shd_d = shd_q;
    if (wr_go_en)  shd_d.go  = wr_go;
    if (wr_sel_en) shd_d.sel = wr_sel;
  end

  // Active copy: whole shadow transferred on update
  always_comb begin
    act_d = act_q;
    if (upd) act_d = shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= CTRL_RST;
      act_q <= CTRL_RST;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act_o     = act_q;
  assign go_rise_o = upd & shd_q.go & ~act_q.go;
endmodule

// File: rtl/calt_div.sv
module calt_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o,
  output logic             cal_clk_o
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = NSEL;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_v, half_v;
  logic             clk_q, clk_d;

  // Ratio is 2 << sel; half period is 1 << sel
  always_comb begin
    last_v = '0;
    half_v = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (sel == SEL_W'(i)) begin
        last_v = CNT_W'((2 << i) - 1);
        half_v = CNT_W'(1 << i);
      end
    end
  end

  assign tick_o = (cnt_q >= last_v);

  always_comb begin
    if (clr)         cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
    clk_d = (cnt_d >= half_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign cal_clk_o = clk_q;
endmodule

// File: rtl/calt_seq.sv
module calt_seq
  import calt_pkg::*;
#(
  parameter int CAL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy_o,
  output logic done_o
);
  localparam int PCNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(CAL_CYCLES - 1);

  calt_state_e      st_q, st_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_BUSY;
          pcnt_d = '0;
        end
      end
      ST_BUSY: begin
        if (tick) begin
          if (pcnt_q == PCNT_LAST) begin
            st_d   = ST_IDLE;
            pcnt_d = '0;
            done_d = 1'b1;
          end else begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      done_q <= done_d;
    end
  end

  assign busy_o = (st_q == ST_BUSY);
  assign done_o = done_q;
endmodule

// File: rtl/calt_top.sv
module calt_top
  import calt_pkg::*;
#(
  parameter int CAL_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go_en,
  input  logic             wr_go,
  input  logic             wr_sel_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             upd,
  input  logic             ref_present,
  output logic             cal_clk,
  output logic             busy,
  output logic             done
);
  logic       srst_n;
  calt_ctrl_t act;
  logic       go_rise;
  logic       start;
  logic       tick;

  calt_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  calt_regs u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_go_en  (wr_go_en),
    .wr_go     (wr_go),
    .wr_sel_en (wr_sel_en),
    .wr_sel    (wr_sel),
    .upd       (upd),
    .act_o     (act),
    .go_rise_o (go_rise)
  );

  assign start = go_rise & ref_present & ~busy;

  calt_div #(.SEL_W(SEL_W)) u_div (
    .clk       (clk),
    .rst_n     (srst_n),
    .clr       (start),
    .sel       (act.sel),
    .tick_o    (tick),
    .cal_clk_o (cal_clk)
  );

  calt_seq #(.CAL_CYCLES(CAL_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (start),
    .tick   (tick),
    .busy_o (busy),
    .done_o (done)
  );
endmodule

// File: rtl/calt_chk.sv
module calt_chk (
  input logic clk,
  input logic rst_n,
  input logic upd,
  input logic ref_present,
  input logic cal_clk,
  input logic busy,
  input logic done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));                      // R7
  AST_START_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(upd));                                  // R2
  AST_START_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_present));                          // R5
  AST_CALCLK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cal_clk);                                    // R9
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);                                              // R7
endmodule

bind calt_top calt_chk u_calt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd         (upd),
  .ref_present (ref_present),
  .cal_clk     (cal_clk),
  .busy        (busy),
  .done        (done)
);

// File: tb/calt_top_bench.sv
module calt_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_go_en = 1'b0, wr_go = 1'b0, wr_sel_en = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic       upd = 1'b0, ref_present = 1'b1;
  logic       cal_clk, busy, done;

  int n_chk = 0;
  int n_fail = 0;
  int q_n[$];          // expected divide ratio per expected run
  bit finished = 1'b0;

  always #2 clk = ~clk;

  calt_top u_calt_top (
    .clk(clk), .rst_n(rst_n), .wr_go_en(wr_go_en), .wr_go(wr_go),
    .wr_sel_en(wr_sel_en), .wr_sel(wr_sel), .upd(upd),
    .ref_present(ref_present), .cal_clk(cal_clk), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: measures each busy pulse and compares with the queued item
  int  len = 0;
  int  cur_n = 0;
  bit  prev_busy = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      len = 0; prev_busy = 1'b0; cur_n = 0;
    end else begin
      if (busy) begin
        len++;
        if (!prev_busy) begin
          if (q_n.size() == 0) begin
            check(1'b0, "R4/R5/R8 unexpected run", 1, 0);
            cur_n = -1;
          end else cur_n = q_n[0];
        end
        if (cur_n > 0 && len == 1)
          check(cal_clk == 1'b0, "R9 cal_clk low at launch", cal_clk, 0);
        if (cur_n > 0 && len == cur_n / 2 + 1)
          check(cal_clk == 1'b1, "R9 cal_clk high after N/2", cal_clk, 1);
      end else if (prev_busy) begin
        check(done == 1'b1, "R7 done after busy", done, 1);
        if (cur_n > 0) begin
          check(len == 64 * cur_n, "R6 busy length", len, 64 * cur_n);
          void'(q_n.pop_front());
        end
        len = 0;
      end else if (done) begin
        check(1'b0, "R7 stray done", 1, 0);
      end
      prev_busy = busy;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit go_en, input bit go, input bit sel_en, input logic [1:0] sel);
    @(negedge clk);
    wr_go_en = go_en; wr_go = go; wr_sel_en = sel_en; wr_sel = sel;
    @(negedge clk);
    wr_go_en = 1'b0; wr_sel_en = 1'b0;
  endtask

  task automatic update();
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  // Driver: full four-step launch, pushes the expected item
  task automatic launch(input logic [1:0] sel, input bit expect_run);
    wr(1'b1, 1'b0, 1'b1, sel);
    update();
    wr(1'b1, 1'b1, 1'b0, 2'b00);
    if (expect_run) q_n.push_back(2 << sel);
    update();
  endtask

  task automatic wait_idle();
    while (q_n.size() != 0 || busy) @(negedge clk);
    cyc(3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cyc(2); rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(cal_clk == 1'b0, "R1 cal_clk after reset", cal_clk, 0);

    // R2: write without update
    wr(1'b1, 1'b1, 1'b1, 2'b00);
    cyc(40);
    check(busy == 1'b0, "R2 write alone no run", busy, 0);

    // R5: transition with no reference
    ref_present = 1'b0;
    update();
    cyc(40);
    check(busy == 1'b0, "R5 no run without reference", busy, 0);
    ref_present = 1'b1;

    // R4: level still 1, update again
    update();
    cyc(40);
    check(busy == 1'b0, "R4 level does not start", busy, 0);

    // R3, R6: each select value
    for (int s = 0; s < 4; s++) begin
      launch(2'(s), 1'b1);
      @(negedge clk);
      check(busy == 1'b1, "R3 busy after final update", busy, 1);
      wait_idle();
    end

    // R8: second sequence inside a running calibration
    launch(2'b00, 1'b1);
    cyc(4);
    wr(1'b1, 1'b0, 1'b0, 2'b00); update();
    wr(1'b1, 1'b1, 1'b0, 2'b00); update();
    wait_idle();
    cyc(200);
    check(busy == 1'b0, "R8 no restart after busy edge", busy, 0);

    // R10 + R1 default ratio: after reset write only the go bit
    do_reset();
    check(busy == 1'b0, "R1 busy after second reset", busy, 0);
    wr(1'b1, 1'b1, 1'b0, 2'b00);   // R10: select keeps default 11
    q_n.push_back(16);
    update();
    wait_idle();

    // R10: select-only write keeps go bit at 0, so update starts nothing
    do_reset();
    wr(1'b0, 1'b1, 1'b1, 2'b01);
    update();
    cyc(40);
    check(busy == 1'b0, "R10 select write leaves go at 0", busy, 0);

    check(q_n.size() == 0, "R3 all expected runs seen", q_n.size(), 0);
    finish_run();
  end
endmodule